// File: doc/BRIEF.md
# FIFO Threshold Interrupt Controller

This block produces the interrupt for a serial controller that has one transmit FIFO and one receive FIFO. Two level-type sources watch the FIFO fill levels. The transmit source is active while the transmit FIFO has drained to a programmed level or below. The receive source is active while the receive FIFO holds more entries than a programmed level. These two sources follow the live levels and are never latched.

Three sticky error sources record misuse of the FIFOs: a write into a full transmit FIFO, a write into a full receive FIFO, and a read from an empty receive FIFO. Each error flag stays set until software writes a one to the matching bit of the clear register.

The raw status is ANDed with a mask to form the masked status. The interrupt line is the registered OR of the masked status. A narrow register-bus write port loads the two thresholds, the mask and the clear register. The FIFOs themselves are built outside this block; it sees only their levels and their push and pop strobes.

Top module: `fifo_irq_ctrl`

## Requirements
- R1: Every status and mask vector uses this source bit order: bit 4 receive-full, bit 3 receive-overflow, bit 2 receive-underflow, bit 1 transmit-overflow, bit 0 transmit-empty. Register addresses are 0 for the transmit threshold, 1 for the receive threshold, 2 for the mask and 3 for the clear register. A write takes effect at the clock edge that samples it. `raw_stat` reflects the inputs sampled at the previous edge.
- R2: Raw bit 0 is set after an edge where `tx_level` is less than or equal to the 5-bit transmit threshold. It is zero otherwise.
- R3: Raw bit 4 is set after an edge where `rx_level` is strictly greater than the 5-bit receive threshold. It is zero otherwise.
- R4: Raw bit 1 sets on `tx_push` while `tx_full` is high. Raw bit 3 sets on `rx_push` while `rx_full` is high. Raw bit 2 sets on `rx_pop` while `rx_empty` is high. A push or pop without the full or empty condition sets nothing.
- R5: Sticky bits 1 to 3 hold their value until cleared. Threshold bits 0 and 4 cannot be cleared by any clear-register write.
- R6: In the clear register, data bit 3 clears transmit-overflow, bit 2 clears receive-overflow, bit 1 clears receive-underflow and bit 0 clears all three. Zero bits and bit 4 have no effect.
- R7: When an error event and a clear of the same flag fall in the same cycle, the flag stays set.
- R8: `mask_stat` equals `raw_stat` ANDed with the mask register. A zero mask forces `mask_stat` to zero.
- R9: `irq` is the OR of `mask_stat` delayed by one clock.
- R10: While `rst` is high, `raw_stat`, `mask_stat` and `irq` are zero. Reset also sets both thresholds and the mask to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_level | input | LVL_W (6) | Transmit FIFO fill level |
| rx_level | input | LVL_W (6) | Receive FIFO fill level |
| tx_push | input | 1 | Write strobe into the transmit FIFO |
| tx_full | input | 1 | Transmit FIFO is full |
| rx_push | input | 1 | Write strobe into the receive FIFO |
| rx_full | input | 1 | Receive FIFO is full |
| rx_pop | input | 1 | Read strobe from the receive FIFO |
| rx_empty | input | 1 | Receive FIFO is empty |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | DATA_W (8) | Register write data |
| raw_stat | output | 5 | Unmasked source status |
| mask_stat | output | 5 | Status after masking |
| irq | output | 1 | Interrupt request |

## Verification
Two functions can act on the same sticky flag in one cycle: an error event sets it, and a clear-register write resets it. The bench provokes this by issuing a pop on an empty receive FIFO in the same cycle as a write of the underflow clear bit. It then judges that the flag is still set on the next cycle, and that a lone clear on the cycle after that removes it. A second same-cycle case applies clear-all while the transmit level is below its threshold. Here the level source must survive while the sticky flags fall.

// File: rtl/fifo_irq_pkg.sv
package fifo_irq_pkg;
  localparam int NSRC = 5;
  // source bit positions, shared by raw, masked and mask vectors
  localparam int SRC_TXE = 0;
  localparam int SRC_TXO = 1;
  localparam int SRC_RXU = 2;
  localparam int SRC_RXO = 3;
  localparam int SRC_RXF = 4;
  // clear-register data bit positions
  localparam int CLB_ALL = 0;
  localparam int CLB_RXU = 1;
  localparam int CLB_RXO = 2;
  localparam int CLB_TXO = 3;
  typedef enum logic [1:0] {
    RA_TXTHR = 2'd0,
    RA_RXTHR = 2'd1,
    RA_MASK  = 2'd2,
    RA_CLR   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_regs.sv
module irq_regs
  import fifo_irq_pkg::*;
#(
  parameter int THR_W  = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [THR_W-1:0]  tx_thr,
  output logic [THR_W-1:0]  rx_thr,
  output logic [NSRC-1:0]   mask,
  output logic [NSRC-1:0]   clr_vec
);
  logic clr_hit;
  assign clr_hit = wr && (reg_sel_e'(addr) == RA_CLR);

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_thr <= '0;
      rx_thr <= '0;
      mask   <= '0;
    end else if (wr) begin
      case (reg_sel_e'(addr))
        RA_TXTHR: tx_thr <= wdata[THR_W-1:0];
        RA_RXTHR: rx_thr <= wdata[THR_W-1:0];
        RA_MASK:  mask   <= wdata[NSRC-1:0];
        default:  ;
      endcase
    end
  end

  // per-source clear pulses; level sources are never clearable
  always_comb begin
    clr_vec          = '0;
    clr_vec[SRC_TXO] = clr_hit && (wdata[CLB_TXO] || wdata[CLB_ALL]);
    clr_vec[SRC_RXO] = clr_hit && (wdata[CLB_RXO] || wdata[CLB_ALL]);
    clr_vec[SRC_RXU] = clr_hit && (wdata[CLB_RXU] || wdata[CLB_ALL]);
  end
endmodule

// File: rtl/irq_level_cmp.sv
module irq_level_cmp #(
  parameter int LVL_W = 6,
  parameter int THR_W = 5,
  parameter bit ABOVE = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LVL_W-1:0] level,
  input  logic [THR_W-1:0] thr,
  output logic             hit
);
  localparam int CMP_W = (LVL_W > THR_W) ? LVL_W : THR_W;
  logic [CMP_W-1:0] lv_x, th_x;
  logic             hit_d;

  assign lv_x = CMP_W'(level);
  assign th_x = CMP_W'(thr);

  generate
    if (ABOVE) begin : g_above
      assign hit_d = lv_x > th_x;
    end else begin : g_at_or_below
      assign hit_d = lv_x <= th_x;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) hit <= 1'b0;
    else     hit <= hit_d;
  end
endmodule

// File: rtl/irq_sticky.sv
module irq_sticky #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] evt,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flag
);
  generate
    for (genvar i = 0; i < N; i++) begin : g_flag
      always_ff @(posedge clk) begin
        if (rst)         flag[i] <= 1'b0;
        else if (evt[i]) flag[i] <= 1'b1;   // event wins over clear
        else if (clr[i]) flag[i] <= 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/fifo_irq_ctrl.sv
module fifo_irq_ctrl
  import fifo_irq_pkg::*;
#(
  parameter int LVL_W  = 6,
  parameter int THR_W  = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LVL_W-1:0]  tx_level,
  input  logic [LVL_W-1:0]  rx_level,
  input  logic              tx_push,
  input  logic              tx_full,
  input  logic              rx_push,
  input  logic              rx_full,
  input  logic              rx_pop,
  input  logic              rx_empty,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [4:0]        raw_stat,
  output logic [4:0]        mask_stat,
  output logic              irq
);
  localparam int NERR = 3;

  logic [THR_W-1:0] tx_thr, rx_thr;
  logic [NSRC-1:0]  mask, clr_vec;
  logic             txe_hit, rxf_hit;
  logic [NERR-1:0]  err_evt, err_clr, err_flag;
  logic             irq_q;

  irq_regs #(.THR_W(THR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .tx_thr(tx_thr), .rx_thr(rx_thr), .mask(mask), .clr_vec(clr_vec)
  );

  irq_level_cmp #(.LVL_W(LVL_W), .THR_W(THR_W), .ABOVE(1'b0)) u_txe (
    .clk(clk), .rst(rst), .level(tx_level), .thr(tx_thr), .hit(txe_hit)
  );

  irq_level_cmp #(.LVL_W(LVL_W), .THR_W(THR_W), .ABOVE(1'b1)) u_rxf (
    .clk(clk), .rst(rst), .level(rx_level), .thr(rx_thr), .hit(rxf_hit)
  );

  // error index 0: tx overflow, 1: rx underflow, 2: rx overflow
  assign err_evt = {rx_push & rx_full, rx_pop & rx_empty, tx_push & tx_full};
  assign err_clr = {clr_vec[SRC_RXO], clr_vec[SRC_RXU], clr_vec[SRC_TXO]};

  irq_sticky #(.N(NERR)) u_err (
    .clk(clk), .rst(rst), .evt(err_evt), .clr(err_clr), .flag(err_flag)
  );

  always_comb begin
    raw_stat          = '0;
    raw_stat[SRC_TXE] = txe_hit;
    raw_stat[SRC_TXO] = err_flag[0];
    raw_stat[SRC_RXU] = err_flag[1];
    raw_stat[SRC_RXO] = err_flag[2];
    raw_stat[SRC_RXF] = rxf_hit;
  end

  assign mask_stat = raw_stat & mask;

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |mask_stat;
  end
  assign irq = irq_q;
endmodule

// File: rtl/fifo_irq_ctrl_chk.sv
module fifo_irq_ctrl_chk #(
  parameter int LVL_W  = 6,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              tx_push,
  input logic              tx_full,
  input logic              rx_push,
  input logic              rx_full,
  input logic              rx_pop,
  input logic              rx_empty,
  input logic              reg_wr,
  input logic [1:0]        reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [4:0]        raw_stat,
  input logic [4:0]        mask_stat,
  input logic              irq
);
  logic c_wr, c_txo, c_rxo, c_rxu;
  assign c_wr  = reg_wr && (reg_addr == 2'd3);
  assign c_txo = c_wr && (reg_wdata[3] || reg_wdata[0]);
  assign c_rxo = c_wr && (reg_wdata[2] || reg_wdata[0]);
  assign c_rxu = c_wr && (reg_wdata[1] || reg_wdata[0]);

  a_r4_txo_set: assert property (@(posedge clk) disable iff (rst)
    (tx_push && tx_full) |=> raw_stat[1]);
  a_r4_rxu_set: assert property (@(posedge clk) disable iff (rst)
    (rx_pop && rx_empty) |=> raw_stat[2]);
  a_r7_rxo_event_beats_clear: assert property (@(posedge clk) disable iff (rst)
    (rx_push && rx_full && c_rxo) |=> raw_stat[3]);
  a_r5_txo_hold: assert property (@(posedge clk) disable iff (rst)
    (raw_stat[1] && !c_txo) |=> raw_stat[1]);
  a_r5_rxu_hold: assert property (@(posedge clk) disable iff (rst)
    (raw_stat[2] && !c_rxu) |=> raw_stat[2]);
  a_r6_txo_clear: assert property (@(posedge clk) disable iff (rst)
    (c_txo && !(tx_push && tx_full)) |=> !raw_stat[1]);
  a_r8_mask_subset: assert property (@(posedge clk) disable iff (rst)
    ((mask_stat & ~raw_stat) == 5'd0));
  a_r9_irq_rise: assert property (@(posedge clk) disable iff (rst)
    (|mask_stat) |=> irq);
  a_r9_irq_fall: assert property (@(posedge clk) disable iff (rst)
    !(|mask_stat) |=> !irq);
endmodule

bind fifo_irq_ctrl fifo_irq_ctrl_chk #(.LVL_W(LVL_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .tx_push(tx_push), .tx_full(tx_full),
  .rx_push(rx_push), .rx_full(rx_full), .rx_pop(rx_pop), .rx_empty(rx_empty),
  .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .raw_stat(raw_stat), .mask_stat(mask_stat), .irq(irq)
);

// File: tb/fifo_irq_ctrl_bench.sv
module fifo_irq_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst;
  logic [5:0] tx_level, rx_level;
  logic       tx_push, tx_full, rx_push, rx_full, rx_pop, rx_empty;
  logic       reg_wr;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [4:0] raw_stat, mask_stat;
  logic       irq;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;   // 250 MHz

  fifo_irq_ctrl u_fifo_irq_ctrl (
    .clk(clk), .rst(rst), .tx_level(tx_level), .rx_level(rx_level),
    .tx_push(tx_push), .tx_full(tx_full), .rx_push(rx_push), .rx_full(rx_full),
    .rx_pop(rx_pop), .rx_empty(rx_empty), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .raw_stat(raw_stat), .mask_stat(mask_stat), .irq(irq)
  );

  typedef struct {
    logic [4:0] raw;
    logic [4:0] msk;
    logic       irq;
    string      tag;
  } exp_t;
  exp_t sb_q[$];

  // bench-side model state
  logic [4:0] m_txthr, m_rxthr, m_mask, m_raw;

  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      n_run++;
      if (raw_stat !== e.raw || mask_stat !== e.msk || irq !== e.irq) begin
        n_fail++;
        $display("FAIL %s: raw=%b msk=%b irq=%b expected raw=%b msk=%b irq=%b",
                 e.tag, raw_stat, mask_stat, irq, e.raw, e.msk, e.irq);
      end
    end
  end

  task automatic cycle(input string tag);
    exp_t       e;
    logic [4:0] clr, rn;
    logic       cw;
    cw  = reg_wr && reg_addr == 2'd3;
    clr = '0;
    if (cw) begin
      clr[1] = reg_wdata[3] | reg_wdata[0];
      clr[3] = reg_wdata[2] | reg_wdata[0];
      clr[2] = reg_wdata[1] | reg_wdata[0];
    end
    rn[0] = tx_level <= {1'b0, m_txthr};
    rn[4] = rx_level > {1'b0, m_rxthr};
    rn[1] = (tx_push & tx_full) | (m_raw[1] & ~clr[1]);
    rn[3] = (rx_push & rx_full) | (m_raw[3] & ~clr[3]);
    rn[2] = (rx_pop & rx_empty) | (m_raw[2] & ~clr[2]);
    e.irq = |(m_raw & m_mask);
    if (reg_wr && reg_addr == 2'd0) m_txthr = reg_wdata[4:0];
    if (reg_wr && reg_addr == 2'd1) m_rxthr = reg_wdata[4:0];
    if (reg_wr && reg_addr == 2'd2) m_mask  = reg_wdata[4:0];
    m_raw = rn;
    e.raw = rn;
    e.msk = rn & m_mask;
    e.tag = tag;
    @(posedge clk);
    sb_q.push_back(e);
    @(negedge clk);
    reg_wr = 0; tx_push = 0; rx_push = 0; rx_pop = 0;
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d, input string tag);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    cycle(tag);
  endtask

  initial begin
    #(4 * 20000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1; tx_level = 6'd20; rx_level = 6'd0;
    tx_push = 0; tx_full = 0; rx_push = 0; rx_full = 0; rx_pop = 0; rx_empty = 0;
    reg_wr = 0; reg_addr = 0; reg_wdata = 0;
    m_txthr = 0; m_rxthr = 0; m_mask = 0; m_raw = 0;
    repeat (3) @(negedge clk);
    n_run++;
    if (raw_stat !== 0 || mask_stat !== 0 || irq !== 0) begin
      n_fail++;
      $display("FAIL R10 reset: raw=%b msk=%b irq=%b expected all zero",
               raw_stat, mask_stat, irq);
    end
    rst = 0;
    cycle("R10 idle after reset, zero mask");
    cycle("R10 idle after reset");
    wr_reg(2'd2, 8'h1F, "R8 mask all");
    cycle("R9 irq stays low");

    // R2 transmit threshold
    tx_level = 6'd0;  cycle("R2 level 0 at threshold 0");
    cycle("R9 irq follows tx-empty");
    tx_level = 6'd1;  cycle("R2 level 1 above threshold 0");
    cycle("R9 irq drops");
    wr_reg(2'd0, 8'd16, "R1 tx threshold write");
    tx_level = 6'd16; cycle("R2 level equals threshold 16");
    tx_level = 6'd17; cycle("R2 level 17 above threshold 16");
    tx_level = 6'd5;  cycle("R2 level 5 below threshold 16");
    tx_level = 6'd40; cycle("R2 level far above");

    // R3 receive threshold
    wr_reg(2'd1, 8'd3, "R1 rx threshold write");
    rx_level = 6'd3;  cycle("R3 level equals threshold 3");
    rx_level = 6'd4;  cycle("R3 level 4 above threshold 3");
    wr_reg(2'd1, 8'd0, "R3 threshold 0 with level 4");
    rx_level = 6'd0;  cycle("R3 level 0 threshold 0");
    rx_level = 6'd1;  cycle("R3 level 1 threshold 0");
    wr_reg(2'd1, 8'd31, "R3 threshold 31");
    rx_level = 6'd31; cycle("R3 level 31 threshold 31");
    rx_level = 6'd32; cycle("R3 level 32 threshold 31");
    rx_level = 6'd0;  cycle("R3 back to empty");

    // R4 sticky sources
    tx_push = 1; tx_full = 0; cycle("R4 push not full sets nothing");
    rx_pop = 1; rx_empty = 0; cycle("R4 pop not empty sets nothing");
    tx_push = 1; tx_full = 1; cycle("R4 tx overflow sets bit 1");
    tx_full = 0;
    rx_push = 1; rx_full = 1; cycle("R4 rx overflow sets bit 3");
    rx_full = 0;
    rx_pop = 1; rx_empty = 1; cycle("R4 rx underflow sets bit 2");
    rx_empty = 0;
    cycle("R5 sticky hold");
    cycle("R5 sticky hold again");

    // R6 clear register
    wr_reg(2'd3, 8'h00, "R6 zero write no effect");
    wr_reg(2'd3, 8'h10, "R6 bit 4 no effect");
    wr_reg(2'd3, 8'h08, "R6 clear tx overflow");
    wr_reg(2'd3, 8'h04, "R6 clear rx overflow");
    wr_reg(2'd3, 8'h02, "R6 clear rx underflow");

    // R5 clear-all leaves level source
    tx_level = 6'd0; rx_level = 6'd32;
    tx_push = 1; tx_full = 1; cycle("R4 tx overflow again");
    rx_pop = 1; rx_empty = 1; cycle("R4 rx underflow again");
    wr_reg(2'd3, 8'h01, "R5 R6 clear all keeps level bits");
    tx_full = 0;

    // R7 event and clear together
    rx_pop = 1; rx_empty = 1;
    wr_reg(2'd3, 8'h02, "R7 underflow with its clear stays set");
    rx_empty = 0;
    wr_reg(2'd3, 8'h02, "R7 lone clear removes it");
    rx_push = 1; rx_full = 1;
    wr_reg(2'd3, 8'h01, "R7 overflow with clear all stays set");
    rx_full = 0;

    // R8 masking
    wr_reg(2'd2, 8'h00, "R8 mask zero silences");
    cycle("R9 irq low after zero mask");
    wr_reg(2'd2, 8'h08, "R8 mask rx overflow only");
    cycle("R9 irq from single source");
    wr_reg(2'd2, 8'h02, "R8 mask tx overflow only (inactive)");
    cycle("R9 irq falls");
    wr_reg(2'd3, 8'h01, "R6 clear all final");
    cycle("R5 final idle");

    repeat (2) @(negedge clk);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule